// File: doc/BRIEF.md
# Cache Line Release Queue with Staged Enqueue

This block holds cache lines that a data cache must write back, or release, to the next level. Each request names a line address, says whether the line carries data, says whether the release must wait for the refill grant of a particular miss, and names that miss. A request is first held for one cycle in a staging register. During that cycle its block-aligned address is compared with every active entry. It then moves into the lowest-numbered free entry, unless a live entry holds the same block.

Entries whose release may go ahead are offered one at a time on a registered release port. The lowest-numbered ready entry goes first. An entry stays busy after its release is taken, until an acknowledgement names its queue index. There are twice as many entries as there are misses. If a grant for the staged request's miss arrives while that request sits in the staging register, the grant is recorded and travels with the request into its entry. Otherwise the entry would wait for a grant that has already passed.

Top module: `wb_release_queue`

## Requirements
- R1: After reset, `full` and `rel_valid` are 0 and `enq_ready` is 1.
- R2: A request taken at a clock edge (`enq_valid` and `enq_ready` both high) occupies the staging register for the next cycle, during which `enq_ready` is 0. If it is not blocked, needs no grant, and the release port is free, `rel_valid` rises at the third rising edge after the request was taken, and not before.
- R3: Addresses are block-aligned by clearing the low `OFFSET_W` bits (default 6). `rel_addr` always has those bits at 0, and comparisons use the aligned value.
- R4: A staged request whose aligned address equals that of any non-idle entry stays in the staging register, with `enq_ready` held at 0, until that entry is freed.
- R5: The queue has `ENTRIES` = 2 × `MISS_ENTRIES` entries (default 32 and 16). While all entries are busy, `full` is 1 and `enq_ready` is 0, and `enq_valid` is ignored: no such request is ever released.
- R6: A grant (`grant_valid` with `grant_miss_id`) that matches the staged request's miss id, and arrives while the request waits in the staging register, is kept. The request is then releasable as soon as it is allocated.
- R7: With `enq_wait_grant` = 1, an entry is not released until a grant for its miss id arrives. With `enq_wait_grant` = 0, it is releasable on allocation. `rel_miss_id` and `rel_has_data` report the values that were enqueued.
- R8: While `rel_valid` is 1 and `rel_ready` is 0, `rel_valid`, `rel_addr` and `rel_id` do not change.
- R9: A request is placed in the lowest-numbered free entry, which `rel_id` reports. The entry becomes free again only when `ack_valid` arrives with `ack_id` equal to that index, after its release has been taken.
- R10: When several entries are ready, they are released in ascending index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue request present |
| enq_ready | output | 1 | Staging register empty and queue not full |
| enq_addr | input | ADDR_W | Line address of the request |
| enq_has_data | input | 1 | Release carries line data |
| enq_wait_grant | input | 1 | Release must wait for the miss grant |
| enq_miss_id | input | MISS_ID_W | Miss the request belongs to |
| grant_valid | input | 1 | Refill grant seen for a miss |
| grant_miss_id | input | MISS_ID_W | Miss the grant belongs to |
| rel_valid | output | 1 | Release offered |
| rel_ready | input | 1 | Release taken this cycle |
| rel_addr | output | ADDR_W | Block-aligned release address |
| rel_has_data | output | 1 | Release carries data |
| rel_miss_id | output | MISS_ID_W | Miss id recorded with the entry |
| rel_id | output | ENTRY_ID_W | Queue index of the released entry |
| ack_valid | input | 1 | Release acknowledged |
| ack_id | input | ENTRY_ID_W | Entry being acknowledged |
| full | output | 1 | Every entry busy |

## Verification
The assertions assume that `ack_id` only names an entry whose release has already been taken, and that `grant_valid` is a single-cycle pulse per miss. They also assume that inputs settle between clock edges. The bench changes every input on the falling edge. It acknowledges an entry only after that entry has been seen on the release port and taken, and it pulses each grant for exactly one cycle. The blocked-in-staging case is reached by keeping an entry for the same block waiting on a different miss while the staged request's own grant passes by.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
  typedef enum logic [1:0] {
    E_IDLE       = 2'd0,
    E_WAIT_GRANT = 2'd1,
    E_READY      = 2'd2,
    E_WAIT_ACK   = 2'd3
  } wbq_state_e;
endpackage

// File: rtl/wbq_lowest_pick.sv
// One-hot of the lowest set bit of a request vector.
module wbq_lowest_pick #(
  parameter int N = 32
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  assign pick = req & (~req + N'(1));
endmodule

// File: rtl/wbq_delay_stage.sv
// Holds one request for a cycle so the address compare has its own cycle.
module wbq_delay_stage #(
  parameter int ADDR_W    = 32,
  parameter int OFFSET_W  = 6,
  parameter int MISS_ID_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_take,
  input  logic [ADDR_W-1:0]    in_addr,
  input  logic                 in_data,
  input  logic                 in_wait,
  input  logic [MISS_ID_W-1:0] in_miss,
  input  logic                 grant_valid,
  input  logic [MISS_ID_W-1:0] grant_miss,
  input  logic                 consume,
  output logic                 stg_valid,
  output logic [ADDR_W-1:0]    stg_addr,
  output logic                 stg_data,
  output logic [MISS_ID_W-1:0] stg_miss,
  output logic                 stg_rel_ok
);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'((64'd1 << OFFSET_W) - 64'd1);

  logic wait_q, granted_q, grant_hit;

  assign grant_hit  = grant_valid && (grant_miss == stg_miss);
  assign stg_rel_ok = !wait_q || granted_q || grant_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_valid <= 1'b0;
      stg_addr  <= '0;
      stg_data  <= 1'b0;
      stg_miss  <= '0;
      wait_q    <= 1'b0;
      granted_q <= 1'b0;
    end else if (in_take) begin
      stg_valid <= 1'b1;
      stg_addr  <= in_addr & ~OFF_MASK;
      stg_data  <= in_data;
      stg_miss  <= in_miss;
      wait_q    <= in_wait;
      granted_q <= grant_valid && (grant_miss == in_miss);
    end else begin
      if (consume) stg_valid <= 1'b0;
      if (stg_valid && grant_hit) granted_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wbq_entry.sv
// One queue slot: grant wait, ready, release in flight, free on ack.
module wbq_entry
  import wbq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MISS_ID_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 alloc,
  input  logic [ADDR_W-1:0]    alloc_addr,
  input  logic                 alloc_data,
  input  logic [MISS_ID_W-1:0] alloc_miss,
  input  logic                 alloc_rel_ok,
  input  logic                 grant_valid,
  input  logic [MISS_ID_W-1:0] grant_miss,
  input  logic                 launch,
  input  logic                 ack,
  input  logic [ADDR_W-1:0]    cmp_addr,
  output logic                 busy_nxt,
  output logic                 is_ready,
  output logic                 match,
  output logic [ADDR_W-1:0]    addr_o,
  output logic                 data_o,
  output logic [MISS_ID_W-1:0] miss_o
);
  wbq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      E_IDLE:       if (alloc) state_d = alloc_rel_ok ? E_READY : E_WAIT_GRANT;
      E_WAIT_GRANT: if (grant_valid && grant_miss == miss_o) state_d = E_READY;
      E_READY:      if (launch) state_d = E_WAIT_ACK;
      E_WAIT_ACK:   if (ack) state_d = E_IDLE;
      default:      state_d = E_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= E_IDLE;
    else     state_q <= state_d;
  end

  // Payload has no reset so it maps to plain storage.
  always_ff @(posedge clk) begin
    if (alloc) begin
      addr_o <= alloc_addr;
      data_o <= alloc_data;
      miss_o <= alloc_miss;
    end
  end

  assign busy_nxt = (state_d != E_IDLE);
  assign is_ready = (state_q == E_READY);
  assign match    = (state_q != E_IDLE) && (addr_o == cmp_addr);
endmodule

// File: rtl/wb_release_queue.sv
module wb_release_queue #(
  parameter int ADDR_W       = 32,
  parameter int OFFSET_W     = 6,
  parameter int MISS_ENTRIES = 16,
  localparam int ENTRIES     = 2 * MISS_ENTRIES,
  localparam int MISS_ID_W   = $clog2(MISS_ENTRIES),
  localparam int ENTRY_ID_W  = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enq_valid,
  output logic                  enq_ready,
  input  logic [ADDR_W-1:0]     enq_addr,
  input  logic                  enq_has_data,
  input  logic                  enq_wait_grant,
  input  logic [MISS_ID_W-1:0]  enq_miss_id,
  input  logic                  grant_valid,
  input  logic [MISS_ID_W-1:0]  grant_miss_id,
  output logic                  rel_valid,
  input  logic                  rel_ready,
  output logic [ADDR_W-1:0]     rel_addr,
  output logic                  rel_has_data,
  output logic [MISS_ID_W-1:0]  rel_miss_id,
  output logic [ENTRY_ID_W-1:0] rel_id,
  input  logic                  ack_valid,
  input  logic [ENTRY_ID_W-1:0] ack_id,
  output logic                  full
);
  logic                 stg_valid, stg_data, stg_rel_ok, alloc_go;
  logic [ADDR_W-1:0]    stg_addr;
  logic [MISS_ID_W-1:0] stg_miss;

  logic [ENTRIES-1:0] match_vec, ready_vec, busy_nxt_vec;
  logic [ENTRIES-1:0] alloc_vec, launch_vec, ready_pick, free_pick;
  logic [ENTRIES-1:0] free_oh_q;
  logic               full_q, load;

  logic [ADDR_W-1:0]    e_addr [ENTRIES];
  logic                 e_data [ENTRIES];
  logic [MISS_ID_W-1:0] e_miss [ENTRIES];

  assign enq_ready = !full_q && !stg_valid;
  assign full      = full_q;

  wbq_delay_stage #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .MISS_ID_W(MISS_ID_W)
  ) u_stage (
    .clk(clk), .rst(rst),
    .in_take(enq_valid && enq_ready),
    .in_addr(enq_addr), .in_data(enq_has_data),
    .in_wait(enq_wait_grant), .in_miss(enq_miss_id),
    .grant_valid(grant_valid), .grant_miss(grant_miss_id),
    .consume(alloc_go),
    .stg_valid(stg_valid), .stg_addr(stg_addr), .stg_data(stg_data),
    .stg_miss(stg_miss), .stg_rel_ok(stg_rel_ok)
  );

  assign alloc_go  = stg_valid && !(|match_vec) && (|free_oh_q);
  assign alloc_vec = alloc_go ? free_oh_q : '0;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    wbq_entry #(.ADDR_W(ADDR_W), .MISS_ID_W(MISS_ID_W)) u_entry (
      .clk(clk), .rst(rst),
      .alloc(alloc_vec[i]),
      .alloc_addr(stg_addr), .alloc_data(stg_data),
      .alloc_miss(stg_miss), .alloc_rel_ok(stg_rel_ok),
      .grant_valid(grant_valid), .grant_miss(grant_miss_id),
      .launch(launch_vec[i]),
      .ack(ack_valid && (ack_id == ENTRY_ID_W'(i))),
      .cmp_addr(stg_addr),
      .busy_nxt(busy_nxt_vec[i]), .is_ready(ready_vec[i]),
      .match(match_vec[i]),
      .addr_o(e_addr[i]), .data_o(e_data[i]), .miss_o(e_miss[i])
    );
  end

  // Next free slot is chosen a cycle ahead from the next busy vector.
  wbq_lowest_pick #(.N(ENTRIES)) u_free_pick (.req(~busy_nxt_vec), .pick(free_pick));

  always_ff @(posedge clk) begin
    if (rst) begin
      free_oh_q <= ENTRIES'(1);
      full_q    <= 1'b0;
    end else begin
      free_oh_q <= free_pick;
      full_q    <= &busy_nxt_vec;
    end
  end

  wbq_lowest_pick #(.N(ENTRIES)) u_rel_pick (.req(ready_vec), .pick(ready_pick));

  assign load       = (!rel_valid || rel_ready) && (|ready_vec);
  assign launch_vec = load ? ready_pick : '0;

  logic [ADDR_W-1:0]     sel_addr;
  logic                  sel_data;
  logic [MISS_ID_W-1:0]  sel_miss;
  logic [ENTRY_ID_W-1:0] sel_id;

  always_comb begin
    sel_addr = '0;
    sel_data = 1'b0;
    sel_miss = '0;
    sel_id   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ready_pick[i]) begin
        sel_addr = sel_addr | e_addr[i];
        sel_data = sel_data | e_data[i];
        sel_miss = sel_miss | e_miss[i];
        sel_id   = sel_id   | ENTRY_ID_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_valid    <= 1'b0;
      rel_addr     <= '0;
      rel_has_data <= 1'b0;
      rel_miss_id  <= '0;
      rel_id       <= '0;
    end else if (load) begin
      rel_valid    <= 1'b1;
      rel_addr     <= sel_addr;
      rel_has_data <= sel_data;
      rel_miss_id  <= sel_miss;
      rel_id       <= sel_id;
    end else if (rel_ready) begin
      rel_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/wbq_checker.sv
module wbq_checker #(
  parameter int ADDR_W     = 32,
  parameter int OFFSET_W   = 6,
  parameter int ENTRY_ID_W = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  enq_valid,
  input logic                  enq_ready,
  input logic                  full,
  input logic                  rel_valid,
  input logic                  rel_ready,
  input logic [ADDR_W-1:0]     rel_addr,
  input logic [ENTRY_ID_W-1:0] rel_id
);
  assert_full_rejects_R5: assert property (@(posedge clk) disable iff (rst)
    full |-> !enq_ready);

  assert_take_holds_stage_R2: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && enq_ready) |=> !enq_ready);

  assert_rel_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> (rel_addr[OFFSET_W-1:0] == '0));

  assert_rel_held_R8: assert property (@(posedge clk) disable iff (rst)
    (rel_valid && !rel_ready) |=> (rel_valid && $stable(rel_addr) && $stable(rel_id)));

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (!rel_valid && !full));
endmodule

bind wb_release_queue wbq_checker #(
  .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .ENTRY_ID_W(ENTRY_ID_W)
) u_wbq_checker (
  .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_ready(enq_ready),
  .full(full), .rel_valid(rel_valid), .rel_ready(rel_ready),
  .rel_addr(rel_addr), .rel_id(rel_id)
);

// File: tb/test_wb_release_queue.sv
`timescale 1ns/1ps
module test_wb_release_queue;
  localparam int ADDR_W = 32;
  localparam int MISS_ENTRIES = 16;
  localparam int ENTRIES = 2 * MISS_ENTRIES;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enq_valid = 1'b0, enq_has_data = 1'b0, enq_wait_grant = 1'b0;
  logic [31:0] enq_addr = '0;
  logic [3:0]  enq_miss_id = '0;
  logic        grant_valid = 1'b0;
  logic [3:0]  grant_miss_id = '0;
  logic        rel_ready = 1'b0, ack_valid = 1'b0;
  logic [4:0]  ack_id = '0;
  logic        enq_ready, rel_valid, rel_has_data, full;
  logic [31:0] rel_addr;
  logic [3:0]  rel_miss_id;
  logic [4:0]  rel_id;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wb_release_queue #(.ADDR_W(ADDR_W), .OFFSET_W(6), .MISS_ENTRIES(MISS_ENTRIES)) i_wb_release_queue (
    .clk(clk), .rst(rst),
    .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_addr(enq_addr),
    .enq_has_data(enq_has_data), .enq_wait_grant(enq_wait_grant), .enq_miss_id(enq_miss_id),
    .grant_valid(grant_valid), .grant_miss_id(grant_miss_id),
    .rel_valid(rel_valid), .rel_ready(rel_ready), .rel_addr(rel_addr),
    .rel_has_data(rel_has_data), .rel_miss_id(rel_miss_id), .rel_id(rel_id),
    .ack_valid(ack_valid), .ack_id(ack_id), .full(full)
  );

  // Vector: addr[42:11] data[10] miss[9:6] ack[5] expected id[4:0]
  localparam logic [42:0] VEC [5] = '{
    {32'h0000_1234, 1'b1, 4'd1,  1'b1, 5'd0},
    {32'h0000_2045, 1'b0, 4'd2,  1'b0, 5'd0},
    {32'h0000_307F, 1'b1, 4'd3,  1'b0, 5'd1},
    {32'h8000_0001, 1'b0, 4'd15, 1'b1, 5'd2},
    {32'h0000_40C0, 1'b1, 4'd0,  1'b1, 5'd2}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic enq(input logic [31:0] a, input logic d, input logic w, input logic [3:0] m);
    while (!enq_ready) @(negedge clk);
    enq_valid = 1'b1; enq_addr = a; enq_has_data = d; enq_wait_grant = w; enq_miss_id = m;
    @(negedge clk);
    enq_valid = 1'b0;
  endtask

  task automatic wait_rel(input string tag);
    int n = 0;
    while (!rel_valid && n < 60) begin @(negedge clk); n++; end
    chk(rel_valid == 1'b1, tag, rel_valid, 1);
  endtask

  task automatic take_rel();
    rel_ready = 1'b1; @(negedge clk); rel_ready = 1'b0;
  endtask

  task automatic do_ack(input logic [4:0] id);
    ack_valid = 1'b1; ack_id = id; @(negedge clk); ack_valid = 1'b0;
  endtask

  task automatic grant(input logic [3:0] m);
    grant_valid = 1'b1; grant_miss_id = m; @(negedge clk); grant_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(full == 1'b0, "R1 full after reset", full, 0);
    chk(rel_valid == 1'b0, "R1 rel_valid after reset", rel_valid, 0);
    chk(enq_ready == 1'b1, "R1 enq_ready after reset", enq_ready, 1);

    // Vector walk: no-wait requests, timing, fields, slot choice
    for (int v = 0; v < 5; v++) begin
      enq(VEC[v][42:11], VEC[v][10], 1'b0, VEC[v][9:6]);
      chk(enq_ready == 1'b0, "R2 staged cycle enq_ready", enq_ready, 0);
      chk(rel_valid == 1'b0, "R2 no release one edge after take", rel_valid, 0);
      @(negedge clk);
      chk(rel_valid == 1'b0, "R2 no release two edges after take", rel_valid, 0);
      @(negedge clk);
      chk(rel_valid == 1'b1, "R2 release three edges after take", rel_valid, 1);
      chk(rel_addr == (VEC[v][42:11] & ~32'h3F), "R3 aligned address", rel_addr, VEC[v][42:11] & ~32'h3F);
      chk(rel_has_data == VEC[v][10], "R7 data flag", rel_has_data, VEC[v][10]);
      chk(rel_miss_id == VEC[v][9:6], "R7 miss id", rel_miss_id, VEC[v][9:6]);
      chk(rel_id == VEC[v][4:0], "R9 lowest free slot", rel_id, VEC[v][4:0]);
      @(negedge clk);
      chk(rel_valid == 1'b1 && rel_id == VEC[v][4:0], "R8 held while stalled", rel_id, VEC[v][4:0]);
      take_rel();
      if (VEC[v][5]) do_ack(VEC[v][4:0]);
    end
    do_ack(5'd0);
    do_ack(5'd1);

    // Same-block blocking and grant kept while staged
    enq(32'h0000_5000, 1'b1, 1'b1, 4'd9);
    repeat (4) @(negedge clk);
    chk(rel_valid == 1'b0, "R7 waits for grant", rel_valid, 0);
    enq(32'h0000_5010, 1'b0, 1'b1, 4'd7);
    grant(4'd7);
    repeat (5) @(negedge clk);
    chk(enq_ready == 1'b0, "R4 staged request blocked", enq_ready, 0);
    chk(rel_valid == 1'b0, "R4 no release while blocked", rel_valid, 0);
    grant(4'd9);
    wait_rel("R7 release after grant");
    chk(rel_addr == 32'h0000_5000 && rel_miss_id == 4'd9, "R7 first entry released", rel_addr, 32'h5000);
    chk(rel_id == 5'd0, "R9 first entry slot", rel_id, 0);
    take_rel();
    do_ack(5'd0);
    wait_rel("R6 staged grant kept");
    chk(rel_addr == 32'h0000_5000, "R3 block address of second", rel_addr, 32'h5000);
    chk(rel_miss_id == 4'd7, "R6 miss id of granted request", rel_miss_id, 7);
    chk(rel_id == 5'd0, "R9 freed slot reused", rel_id, 0);
    take_rel();
    do_ack(5'd0);

    // Fill every slot, then check rejection and ordering
    for (int k = 0; k < ENTRIES; k++) enq(32'h0001_0000 + 32'(k) * 32'd64, 1'b1, 1'b1, 4'd5);
    @(negedge clk);
    chk(full == 1'b1, "R5 full after all slots used", full, 1);
    chk(enq_ready == 1'b0, "R5 enq_ready low when full", enq_ready, 0);
    enq_valid = 1'b1; enq_addr = 32'hFFFF_0000; enq_wait_grant = 1'b0; enq_miss_id = 4'd2;
    repeat (4) @(negedge clk);
    enq_valid = 1'b0;
    chk(rel_valid == 1'b0, "R5 nothing released when full", rel_valid, 0);
    grant(4'd5);
    for (int k = 0; k < ENTRIES; k++) begin
      wait_rel("R10 drain release");
      chk(rel_id == 5'(k), "R10 ascending order", rel_id, k);
      chk(rel_addr == 32'h0001_0000 + 32'(k) * 32'd64, "R10 address in order", rel_addr, 32'h0001_0000 + k * 64);
      take_rel();
      do_ack(5'(k));
    end
    repeat (10) @(negedge clk);
    chk(rel_valid == 1'b0, "R5 rejected request never released", rel_valid, 0);
    chk(full == 1'b0, "R9 all slots freed", full, 0);
    chk(enq_ready == 1'b1, "R9 ready after drain", enq_ready, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule